// File: doc/BRIEF.md
# Block-to-Memory Input DMA Engine

This engine copies a run of words from a small device-side buffer into system memory without the processor moving each word. Software programs it with three writes to fixed I/O port numbers: the first memory address, the number of words, and a go command. The engine then asks for the shared system bus. Once the bus is granted it performs one memory-write cycle per word, driving the address, the data and a write command. When the last word has been accepted it raises an interrupt and waits for the processor to acknowledge it.

Each memory-write cycle is a valid/ready exchange. `bus_oe` is the valid. It is high only while the bus is granted and a job is running. `mem_ack` is the ready. While `bus_oe` is high and `mem_ack` is low, the memory is exerting back-pressure, and the engine holds address, data and command steady. A word is taken on any rising edge where both are high, and only then do the buffer index, memory address and remaining count move on. The three bus outputs are forced to zero whenever `bus_oe` is low. This is how the tri-state drivers are modelled, and an external transceiver uses `bus_oe` as its enable.

The device buffer is an internal read-only table of `ROM_DEPTH` words. `ROM_DEPTH` must be a power of two. Word k holds (k·37 + 451) mod 2^DATA_W, and the buffer index wraps modulo `ROM_DEPTH`. The word count is used up by a job, so every job must write the count again.

Top module: `dma_in_ctrl`

## Requirements
- R1: After reset, `bus_req`, `bus_oe` and `irq` are low, and `bus_addr`, `bus_data` and `bus_cmd` are zero.
- R2: A write (`cfg_wr` high) to port 1 loads the start address from `cfg_data` and a write to port 2 loads the word count. A write to port 4 is the go command. With a nonzero count, go makes `bus_req` high on the next cycle.
- R3: While `bus_gnt` is low, `bus_oe` is low and the address, data and command outputs are zero, even when `bus_req` is high.
- R4: For the k-th word of a job (k from 0), with the bus granted, `bus_oe` is high and `bus_cmd` is the memory-write code 2'b10. `bus_addr` is start+k and `bus_data` is buffer word k.
- R5: While `bus_oe` is high and `mem_ack` is low, the address and data outputs stay unchanged. They move to the next word only after a cycle where both are high.
- R6: On the cycle after the n-th accepted word, `bus_req` and `bus_oe` are both low and `irq` is high.
- R7: `irq` stays high until `irq_ack` is seen and is low on the cycle after. Each job gives exactly one interrupt.
- R8: A go command with a word count of zero makes `irq` high on the next cycle, and `bus_req` is never raised for that job.
- R9: Port writes are ignored unless the engine is idle. A write is ignored while a job runs or while an interrupt is pending. A start address or count written mid-job does not alter that job, and a go command written while an interrupt is pending starts nothing.
- R10: Every go command restarts the buffer index at zero, so each job begins with buffer word 0.
- R11: `mem_ack` is ignored while `bus_oe` is low, so an acknowledge before grant does not advance any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Processor port write strobe |
| cfg_port | input | PORT_W | Port number of the write (1 address, 2 count, 4 go) |
| cfg_data | input | DATA_W | Write data for address or count |
| bus_req | output | 1 | Bus request, high while a job runs |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_oe | output | 1 | Driver enable and valid of the current write cycle |
| bus_addr | output | ADDR_W | Memory address driven on the bus |
| bus_data | output | DATA_W | Buffer word driven on the bus |
| bus_cmd | output | 2 | Control code, 2'b10 for memory write, else zero |
| mem_ack | input | 1 | Memory accepts the current word (ready) |
| irq | output | 1 | Job-complete interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
A wrong memory address or buffer index is visible on the very first granted write cycle. It shows up as a wrong `bus_addr` or `bus_data` for word k, and a wrong address also leaves memory holes that the bench detects after the job. A word counter that is off by one shows at the end of the job. Either an extra write cycle appears, or `bus_req` drops and `irq` rises one word early, on the cycle after the wrong acknowledge. A state machine that leaks past idle shows as a request after a zero-count go, as a second interrupt, or as a job reshaped by writes made while it runs.

// File: rtl/dma_in_pkg.sv
package dma_in_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } dma_state_e;

  localparam int unsigned PORT_START = 1;
  localparam int unsigned PORT_COUNT = 2;
  localparam int unsigned PORT_GO    = 4;

  localparam logic [1:0] CMD_NONE  = 2'b00;
  localparam logic [1:0] CMD_MEMWR = 2'b10;

  localparam int unsigned ROM_MUL = 37;
  localparam int unsigned ROM_ADD = 451;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_in_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              cfg_wr,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic              idle,
  output logic              ld_addr,
  output logic              ld_cnt,
  output logic              go
);
  logic take;
  assign take    = cfg_wr && idle;
  assign ld_addr = take && (cfg_port == PORT_W'(PORT_START));
  assign ld_cnt  = take && (cfg_port == PORT_W'(PORT_COUNT));
  assign go      = take && (cfg_port == PORT_W'(PORT_GO));
endmodule

// File: rtl/dma_xfer_counters.sv
module dma_xfer_counters #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic              go,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IDX_W-1:0]  buf_idx,
  output logic              cnt_zero,
  output logic              cnt_last
);
  logic [CNT_W-1:0] wcount;

  // buffer index: cleared by go, steps per accepted word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_idx <= '0;
    else if (go)     buf_idx <= '0;
    else if (adv)    buf_idx <= buf_idx + IDX_W'(1);
  end

  // memory address: loadable, steps per accepted word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mem_addr <= '0;
    else if (ld_addr) mem_addr <= addr_in;
    else if (adv)     mem_addr <= mem_addr + ADDR_W'(1);
  end

  // remaining words: preset, count down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcount <= '0;
    else if (ld_cnt) wcount <= cnt_in;
    else if (adv)    wcount <= wcount - CNT_W'(1);
  end

  assign cnt_zero = (wcount == '0);
  assign cnt_last = (wcount == CNT_W'(1));

  // count only moves on a load or an accepted word
  assert_count_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_cnt && !adv) |=> $stable(wcount));

  // a go always restarts the buffer at word 0
  assert_index_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (buf_idx == '0));
endmodule

// File: rtl/dma_src_rom.sv
module dma_src_rom
  import dma_in_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign table_q[i] = DATA_W'(i * ROM_MUL + ROM_ADD);
  end

  assign word = table_q[idx];
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_in_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cnt_zero,
  input  logic cnt_last,
  input  logic bus_gnt,
  input  logic mem_ack,
  input  logic irq_ack,
  output logic idle,
  output logic bus_req,
  output logic bus_oe,
  output logic adv,
  output logic irq
);
  dma_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (go) state_nx = cnt_zero ? ST_DONE : ST_BUSY;
      ST_BUSY: if (adv && cnt_last) state_nx = ST_DONE;
      ST_DONE: if (irq_ack) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign idle    = (state == ST_IDLE);
  assign bus_req = (state == ST_BUSY);
  assign bus_oe  = bus_req && bus_gnt;
  assign adv     = bus_oe && mem_ack;
  assign irq     = (state == ST_DONE);

  assert_release_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_last) |=> (irq && !bus_req && !bus_oe));

  assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack) |=> !irq);

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && go && cnt_zero) |=> (irq && !bus_req));
endmodule

// File: rtl/dma_in_ctrl.sv
module dma_in_ctrl
  import dma_in_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8,
  parameter int ROM_DEPTH = 16,
  parameter int PORT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic [1:0]        bus_cmd,
  input  logic              mem_ack,
  output logic              irq,
  input  logic              irq_ack
);
  localparam int IDX_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

  logic              idle, ld_addr, ld_cnt, go, adv, cnt_zero, cnt_last;
  logic [ADDR_W-1:0] mem_addr;
  logic [IDX_W-1:0]  buf_idx;
  logic [DATA_W-1:0] rom_word;

  dma_port_decode #(.PORT_W(PORT_W)) u_dec (
    .cfg_wr(cfg_wr), .cfg_port(cfg_port), .idle(idle),
    .ld_addr(ld_addr), .ld_cnt(ld_cnt), .go(go)
  );

  dma_xfer_counters #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_addr(ld_addr), .ld_cnt(ld_cnt), .go(go),
    .adv(adv), .addr_in(ADDR_W'(cfg_data)), .cnt_in(CNT_W'(cfg_data)),
    .mem_addr(mem_addr), .buf_idx(buf_idx),
    .cnt_zero(cnt_zero), .cnt_last(cnt_last)
  );

  dma_src_rom #(.DATA_W(DATA_W), .DEPTH(ROM_DEPTH), .IDX_W(IDX_W)) u_rom (
    .idx(buf_idx), .word(rom_word)
  );

  dma_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .bus_gnt(bus_gnt), .mem_ack(mem_ack), .irq_ack(irq_ack),
    .idle(idle), .bus_req(bus_req), .bus_oe(bus_oe), .adv(adv), .irq(irq)
  );

  // modelled tri-state: values reach the bus only with the enable
  assign bus_addr = bus_oe ? mem_addr : '0;
  assign bus_data = bus_oe ? rom_word : '0;
  assign bus_cmd  = bus_oe ? CMD_MEMWR : CMD_NONE;

  // back-pressure: a stalled word keeps its address and data
  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !mem_ack) ##1 bus_oe |-> ($stable(bus_addr) && $stable(bus_data)));
endmodule

// File: tb/sim_dma_in_ctrl.sv
module sim_dma_in_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_port = '0;
  logic [15:0] cfg_data = '0;
  logic        bus_gnt = 1'b0, mem_ack = 1'b0, irq_ack = 1'b0;
  logic        bus_req, bus_oe, irq;
  logic [15:0] bus_addr, bus_data;
  logic [1:0]  bus_cmd;

  int total = 0, bad = 0;
  int irq_cnt = 0, early_drv = 0;
  logic [15:0] mem [0:255];

  always #2 clk = ~clk;

  dma_in_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_port(cfg_port), .cfg_data(cfg_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_oe(bus_oe), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_cmd(bus_cmd), .mem_ack(mem_ack), .irq(irq), .irq_ack(irq_ack)
  );

  always @(posedge irq) irq_cnt++;
  always @(negedge clk) begin
    #1;
    if (bus_oe && !bus_gnt) early_drv++;
  end

  function automatic logic [15:0] rom_word(int k);
    return 16'(((k % 16) * 37 + 451));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(int p, int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_port = 4'(p); cfg_data = 16'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_job(int start, int n, int gnt_dly, int stall, bit poke);
    int irq0 = irq_cnt;
    cfg_write(1, start);
    cfg_write(2, n);
    cfg_write(4, 0);
    #1;
    check(bus_req == 1'b1, "R2 request after go", bus_req, 1);
    // grant withheld; an early ack must be ignored
    mem_ack = 1'b1;
    #1;
    check(bus_oe == 1'b0 && bus_addr == 0 && bus_cmd == 0, "R3 no drive before grant",
          {bus_oe, bus_cmd}, 0);
    for (int i = 0; i < gnt_dly; i++) begin
      @(negedge clk);
      mem_ack = 1'b0;
    end
    bus_gnt = 1'b1;
    for (int k = 0; k < n; k++) begin
      for (int w = 0; w <= stall; w++) begin
        cfg_wr = 1'b0;
        if (poke && w == 0 && k == 1) begin cfg_wr = 1'b1; cfg_port = 4'd1; cfg_data = 16'h0080; end
        if (poke && w == 0 && k == 2) begin cfg_wr = 1'b1; cfg_port = 4'd2; cfg_data = 16'd9; end
        mem_ack = (w == stall);
        #1;
        if (w == 0 || w == stall) begin
          check(bus_oe && bus_cmd == 2'b10, "R4 write cycle active", {bus_oe, bus_cmd}, 3'b110);
          check(bus_addr == 16'(start + k), (w > 0) ? "R5 address held" : "R4 address",
                bus_addr, start + k);
          check(bus_data == rom_word(k), (k == 0) ? "R11/R10 first word" : "R4 data",
                bus_data, rom_word(k));
        end
        if (mem_ack) mem[8'(bus_addr)] = bus_data;
        @(negedge clk);
      end
    end
    cfg_wr = 1'b0;
    mem_ack = 1'b0;
    #1;
    check(!bus_req && !bus_oe && irq, "R6 release and interrupt", {bus_req, bus_oe, irq}, 1);
    bus_gnt = 1'b0;
    @(negedge clk);
    check(irq == 1'b1, "R7 interrupt held", irq, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    #1;
    check(irq == 1'b0, "R7 interrupt cleared", irq, 0);
    check(irq_cnt == irq0 + 1, "R7 one interrupt", irq_cnt - irq0, 1);
    for (int k = 0; k < n; k++)
      check(mem[8'(start + k)] == rom_word(k), "R4 memory contents",
            mem[8'(start + k)], rom_word(k));
  endtask

  task automatic t_reset();
    #1;
    check(!bus_req && !bus_oe && !irq, "R1 control low", {bus_req, bus_oe, irq}, 0);
    check(bus_addr == 0 && bus_data == 0 && bus_cmd == 0, "R1 bus zero", bus_addr, 0);
  endtask

  task automatic t_zero_count();
    int irq0 = irq_cnt;
    cfg_write(2, 0);
    cfg_write(4, 0);
    #1;
    check(irq == 1'b1 && bus_req == 1'b0, "R8 immediate interrupt", {irq, bus_req}, 2);
    // go while interrupt pending is ignored
    cfg_write(4, 0);
    #1;
    check(bus_req == 1'b0, "R9 go ignored while pending", bus_req, 0);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(bus_req == 1'b0 && irq == 1'b0, "R9 no job from ignored go", {bus_req, irq}, 0);
    check(irq_cnt == irq0 + 1, "R8 single interrupt", irq_cnt - irq0, 1);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_job(16'h0040, 5, 3, 0, 1'b0);   // R2 R3 R4 R6 R7 R11
    run_job(16'h00F0, 3, 1, 2, 1'b0);   // R5 R10
    t_zero_count();                     // R8 R9
    run_job(16'h0010, 4, 2, 1, 1'b1);   // R9 writes mid-job
    check(mem[8'h14] == 16'hDEAD, "R9 count unchanged by mid-job write", mem[8'h14], 16'hDEAD);
    check(mem[8'h80] == 16'hDEAD, "R9 address unchanged by mid-job write", mem[8'h80], 16'hDEAD);
    check(early_drv == 0, "R3 never drove without grant", early_drv, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule